// File: doc/BRIEF.md
# Storage Window Address Map

This block keeps the two configuration words that place a memory-mapped inter-thread storage window in the address space and decide how it is divided into cells. Software reaches the words through a small register port. Each word is selected by an index taken from the address bits above bit 3. A write changes only the fields that are defined as writable and leaves every other bit of the word as it was. An index that names no word is rejected and reported.

From the stored words the block derives four values: the window base, an enable, a window size and a per-cell stride. It then decodes a storage address, combinationally, into three results: an in-window hit, a cell select and a view code. The cells themselves sit outside this block and consume these three results.

The window size changes only when a write actually changes a word and the requested size is a power of two. Otherwise the previous size is kept. A cell index beyond the last implemented cell is clamped to the last cell rather than faulting.

Top module: `itc_window_map`

## Requirements
- R1: After reset, word 0 reads 0 and word 1 reads 0x0C00 | (NUM_CELLS << 20). The effective window size is 4096 bytes.
- R2: A write to index 0 updates only bits 31:10 (base) and bit 0 (enable). All other bits of word 0 keep their old value.
- R3: A write to index 1 updates only bits 16:10 (size field) and bits 2:0 (grain). The cell count in bits 27:20 and every other bit are read-only.
- R4: A write to any index other than 0 or 1 changes neither word. It raises `reg_err` for exactly the one cycle after the write.
- R5: With `reg_idx` of 0 or 1, `reg_rdata` shows the stored word in the same cycle. Any other index reads as zero.
- R6: A write that changes either word sets the window size to 1024 + bits 16:10 of the new word 1, if that sum is a power of two. If the sum is not a power of two, the previous size is kept. The new size takes effect on the clock edge that stores the write.
- R7: `st_hit` is 1 exactly when the enable bit is 1 and (`st_addr` with its low log2(size) bits cleared) equals the base, which is word 0 bits 31:10 followed by ten zero bits.
- R8: `st_cell` equals (`st_addr` mod size) shifted right by 7 + grain. If that value is NUM_CELLS or more, `st_cell` is clamped to NUM_CELLS-1.
- R9: `st_view` equals `st_addr` bits 6:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Word index (address bits above bit 3) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_idx` |
| reg_err | output | 1 | Write to an undefined index seen in the previous cycle |
| st_addr | input | 32 | Storage address to decode |
| st_hit | output | 1 | Address falls inside the enabled window |
| st_cell | output | CELL_W | Selected cell, clamped |
| st_view | output | 4 | View code |

## Verification
The bench builds the block with NUM_CELLS = 6. Because six is not a power of two, the offsets decoded at the smallest grain run past the last cell, which exercises the clamp at a realistic window size. A 4-bit index leaves fourteen undefined word slots, so rejected writes and zero reads are easy to reach. Random writes put every size-field value in front of the power-of-two filter, and random addresses fall both inside and just outside the window.

// File: rtl/itc_map_pkg.sv
package itc_map_pkg;
  localparam int          WORD_W      = 64;
  localparam int          ADDR_W      = 32;
  localparam int          SZ_W        = 18;
  localparam int          GRAIN_W     = 3;
  localparam int          VIEW_W      = 4;
  localparam int          VIEW_LSB    = 3;
  localparam int          STRIDE_MIN  = 7;
  localparam int          BASE_LSB    = 10;
  localparam int          BASE_W      = ADDR_W - BASE_LSB;
  localparam int          SZF_LSB     = 10;
  localparam int          SZF_W       = 7;
  localparam int          CNT_LSB     = 20;
  localparam int          CNT_W       = 8;
  localparam logic [WORD_W-1:0] W0_WMASK   = 64'h0000_0000_FFFF_FC01;
  localparam logic [WORD_W-1:0] W1_WMASK   = 64'h0000_0000_0001_FC07;
  localparam logic [WORD_W-1:0] W1_RST_SZF = 64'h0000_0000_0000_0C00;
  localparam logic [SZ_W-1:0]   SZ_RST     = 18'd4096;
  localparam logic [SZ_W-1:0]   SZ_MIN     = 18'd1024;
endpackage

// File: rtl/itc_map_regs.sv
module itc_map_regs
  import itc_map_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_err,
  output logic [WORD_W-1:0] w0_q,
  output logic [WORD_W-1:0] w1_q,
  output logic [WORD_W-1:0] w1_d,
  output logic              wr_chg
);
  localparam logic [WORD_W-1:0] W1_RST =
    W1_RST_SZF | (WORD_W'(NUM_CELLS) << CNT_LSB);

  logic [WORD_W-1:0] w0_d;
  logic              bad_d;
  logic              err_q;

  always_comb begin
    w0_d  = w0_q;
    w1_d  = w1_q;
    bad_d = 1'b0;
    if (reg_wr) begin
      if (reg_idx == IDX_W'(0))
        w0_d = (reg_wdata & W0_WMASK) | (w0_q & ~W0_WMASK);
      else if (reg_idx == IDX_W'(1))
        w1_d = (reg_wdata & W1_WMASK) | (w1_q & ~W1_WMASK);
      else
        bad_d = 1'b1;
    end
    wr_chg = (w0_d != w0_q) || (w1_d != w1_q);
  end

  always_comb begin
    if (reg_idx == IDX_W'(0))      reg_rdata = w0_q;
    else if (reg_idx == IDX_W'(1)) reg_rdata = w1_q;
    else                           reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q  <= '0;
      w1_q  <= W1_RST;
      err_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        w0_q <= w0_d;
        w1_q <= w1_d;
      end
      err_q <= bad_d;
    end
  end

  assign reg_err = err_q;
endmodule

// File: rtl/itc_map_size.sv
module itc_map_size
  import itc_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_chg,
  input  logic [SZF_W-1:0] szf_new,
  output logic [SZ_W-1:0]  win_size
);
  logic [SZ_W-1:0] cand;
  logic            is_pow2;
  logic [SZ_W-1:0] size_q;
  logic            load;

  always_comb begin
    cand    = SZ_MIN + {1'b0, szf_new, {SZF_LSB{1'b0}}};
    is_pow2 = (cand & (cand - SZ_W'(1))) == '0;
    load    = wr_chg && is_pow2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    size_q <= SZ_RST;
    else if (load) size_q <= cand;
  end

  assign win_size = size_q;
endmodule

// File: rtl/itc_map_decode.sv
module itc_map_decode
  import itc_map_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int CELL_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic               win_en,
  input  logic [BASE_W-1:0]  win_base,
  input  logic [SZ_W-1:0]    win_size,
  input  logic [GRAIN_W-1:0] grain,
  output logic               st_hit,
  output logic [CELL_W-1:0]  st_cell,
  output logic [VIEW_W-1:0]  st_view
);
  logic [ADDR_W-1:0] low_mask;
  logic [SZ_W-1:0]   offset;
  logic [3:0]        shamt;
  logic [SZ_W-1:0]   raw_idx;

  always_comb begin
    low_mask = ADDR_W'(win_size) - ADDR_W'(1);
    st_hit   = win_en && ((st_addr & ~low_mask) == {win_base, {BASE_LSB{1'b0}}});
    offset   = st_addr[SZ_W-1:0] & low_mask[SZ_W-1:0];
    shamt    = 4'(STRIDE_MIN) + {1'b0, grain};
    raw_idx  = offset >> shamt;
    if (raw_idx >= SZ_W'(NUM_CELLS)) st_cell = CELL_W'(NUM_CELLS - 1);
    else                             st_cell = raw_idx[CELL_W-1:0];
    st_view  = st_addr[VIEW_LSB +: VIEW_W];
  end
endmodule

// File: rtl/itc_window_map.sv
module itc_window_map
  import itc_map_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int IDX_W     = 4,
  parameter int CELL_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_err,
  input  logic [31:0]       st_addr,
  output logic              st_hit,
  output logic [CELL_W-1:0] st_cell,
  output logic [3:0]        st_view
);
  logic [WORD_W-1:0] w0_q, w1_q, w1_d;
  logic              wr_chg;
  logic [SZ_W-1:0]   win_size;

  itc_map_regs #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .w0_q(w0_q), .w1_q(w1_q), .w1_d(w1_d), .wr_chg(wr_chg)
  );

  itc_map_size u_size (
    .clk(clk), .rst_n(rst_n), .wr_chg(wr_chg),
    .szf_new(w1_d[SZF_LSB +: SZF_W]), .win_size(win_size)
  );

  itc_map_decode #(.NUM_CELLS(NUM_CELLS), .CELL_W(CELL_W)) u_dec (
    .st_addr(st_addr), .win_en(w0_q[0]), .win_base(w0_q[BASE_LSB +: BASE_W]),
    .win_size(win_size), .grain(w1_q[GRAIN_W-1:0]),
    .st_hit(st_hit), .st_cell(st_cell), .st_view(st_view)
  );
endmodule

// File: rtl/itc_window_map_chk.sv
module itc_window_map_chk #(
  parameter int NUM_CELLS = 8,
  parameter int IDX_W     = 4,
  parameter int CELL_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              reg_err,
  input logic [63:0]       w0_q,
  input logic [63:0]       w1_q,
  input logic [17:0]       win_size,
  input logic              st_hit,
  input logic [CELL_W-1:0] st_cell
);
  AST_BAD_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx > IDX_W'(1)) |=> reg_err); // R4
  AST_BAD_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx > IDX_W'(1)) |=> ($stable(w0_q) && $stable(w1_q))); // R4
  AST_NO_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(w0_q) && $stable(w1_q) && $stable(win_size))); // R6
  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_size) == 1); // R6
  AST_CNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    w1_q[27:20] == 8'(NUM_CELLS)); // R3
  AST_CELL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    st_cell <= CELL_W'(NUM_CELLS - 1)); // R8
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !w0_q[0] |-> !st_hit); // R7
endmodule

bind itc_window_map itc_window_map_chk #(
  .NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W), .CELL_W(CELL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .reg_err(reg_err), .w0_q(w0_q), .w1_q(w1_q), .win_size(win_size),
  .st_hit(st_hit), .st_cell(st_cell)
);

// File: tb/itc_window_map_tb.sv
module itc_window_map_tb;
  localparam int NC     = 6;
  localparam int IW     = 4;
  localparam int CW     = 3;
  localparam logic [63:0] M0 = 64'h0000_0000_FFFF_FC01;
  localparam logic [63:0] M1 = 64'h0000_0000_0001_FC07;

  logic          clk, rst_n, reg_wr, reg_err, st_hit;
  logic [IW-1:0] reg_idx;
  logic [63:0]   reg_wdata, reg_rdata;
  logic [31:0]   st_addr;
  logic [CW-1:0] st_cell;
  logic [3:0]    st_view;

  int checks = 0;
  int fails  = 0;
  logic [63:0] m0, m1;
  logic [31:0] msz;

  itc_window_map #(.NUM_CELLS(NC), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .st_addr(st_addr), .st_hit(st_hit), .st_cell(st_cell), .st_view(st_view)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [31:0] a);
    return m0[0] && ((a & ~(msz - 32'd1)) == {m0[31:10], 10'b0});
  endfunction

  function automatic logic [CW-1:0] exp_cell(input logic [31:0] a);
    logic [31:0] i;
    i = (a & (msz - 32'd1)) >> (7 + int'(m1[2:0]));
    return (i >= NC) ? CW'(NC - 1) : i[CW-1:0];
  endfunction

  task automatic do_write(input logic [IW-1:0] idx, input logic [63:0] d);
    logic [63:0] n0, n1;
    logic [31:0] cand;
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    n0 = m0; n1 = m1;
    if (idx == 0) n0 = (d & M0) | (m0 & ~M0);
    else if (idx == 1) n1 = (d & M1) | (m1 & ~M1);
    if (n0 != m0 || n1 != m1) begin
      cand = 32'd1024 + {15'b0, n1[16:10], 10'b0};
      if ((cand & (cand - 1)) == 0) msz = cand;
    end
    m0 = n0; m1 = n1;
    chk("R4 reg_err", {63'b0, reg_err}, {63'b0, idx > 1});
  endtask

  task automatic check_regs();
    reg_idx = 0; #1 chk("R2 word0", reg_rdata, m0);
    reg_idx = 1; #1 chk("R3 word1", reg_rdata, m1);
    reg_idx = IW'(2 + $urandom_range(0, 13)); #1 chk("R5 undefined read", reg_rdata, 64'd0);
  endtask

  task automatic check_dec(input logic [31:0] a);
    st_addr = a; #1;
    chk("R7 hit", {63'b0, st_hit}, {63'b0, exp_hit(a)});
    chk("R8 cell", 64'(st_cell), 64'(exp_cell(a)));
    chk("R9 view", 64'(st_view), 64'(a[6:3]));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0; st_addr = '0;
    m0 = '0; m1 = 64'h0C00 | (64'(NC) << 20); msz = 32'd4096;
    #20; @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    reg_idx = 0; #1 chk("R1 word0 reset", reg_rdata, 64'd0);
    reg_idx = 1; #1 chk("R1 word1 reset", reg_rdata, 64'h0C00 | (64'(NC) << 20));
    chk("R1 reg_err reset", {63'b0, reg_err}, 64'd0);
    check_dec(32'h0000_0F80);
    // R2 masked write to word 0, window at zero enabled
    do_write(0, 64'hFFFF_FFFF_0000_0001);
    check_regs();
    check_dec(32'h0000_0F80);   // R8 clamp at 4 KB / 128 B stride
    check_dec(32'h0000_0FFF);   // R1 size 4096 -> inside
    check_dec(32'h0000_1000);   // outside
    // R6 non power of two keeps size
    do_write(1, 64'h0000_0800);
    check_regs();
    check_dec(32'h0000_0C08);   // still hit with 4096 window
    // R6 power of two: field 7 -> 8 KB, grain 2
    do_write(1, 64'hFFFF_FFFF_FFF0_1C02);
    check_regs();
    check_dec(32'h0000_1E38);
    check_dec(32'h0000_2000);
    // R4 undefined index
    do_write(5, 64'hFFFF_FFFF_FFFF_FFFF);
    check_regs();
    // R7 disabled window never hits
    do_write(0, 64'h0000_0000_0002_0000);
    check_dec(32'h0002_0010);
    for (int n = 0; n < 3000; n++) begin
      logic [IW-1:0] idx;
      logic [63:0]   d;
      idx = ($urandom_range(0, 9) < 8) ? IW'($urandom_range(0, 1)) : IW'($urandom_range(2, 15));
      d = {$urandom, $urandom};
      if (idx == 0 && $urandom_range(0, 3) != 0) d[16:1] = '0;
      if (idx == 0 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      do_write(idx, d);
      if (n % 8 == 0) check_regs();
      for (int k = 0; k < 3; k++) begin
        logic [31:0] a;
        if ($urandom_range(0, 3) != 0)
          a = {m0[31:10], 10'b0} + ($urandom & ((msz << 1) - 1));
        else
          a = $urandom;
        check_dec(a);
      end
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule